// File: doc/BRIEF.md
# Directory Home Controller for Cluster Coherence

This block is the home side of a directory coherence scheme for a machine built from clusters. Each cluster's memory is served by one such controller. For every memory block it holds, the controller keeps one entry: a 2-bit state and a presence bitmap with one bit per cluster. The state is one of three. UNCACHED means only memory has the block. CLEAN means memory is current and any number of clusters may hold copies. DIRTY means memory is stale and exactly one cluster holds the block. The home owns UNCACHED and CLEAN blocks. The single holder owns a DIRTY block.

Clusters send read, write (ownership) and writeback requests on a valid/ready request channel. The controller answers on a separate valid/ready message channel, which carries the destination cluster, a message type and the block address. For a write to a shared block, it first sends an invalidate to every other holder and grants only once all of them have acknowledged. For a block held dirty elsewhere, it forwards the request to the owner and finishes once the owner reports completion. Acknowledgements arrive on a third input with no backpressure.

Only one multi-step transaction is outstanding at a time. While it runs, requests that complete at once are still served. Requests to the busy block, and requests that would need a second wait, are refused with a retry message.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every entry is UNCACHED with an empty bitmap, req_ready is 1 and msg_valid is 0. A first read of any block is answered with a shared grant from memory.
- R2: The directory index is req_addr[OFFW +: IDXW], where OFFW is log2 of the 16-byte block size. The low 4 offset bits are ignored. msg_addr always carries the region and index with the offset bits at zero.
- R3: A read (req_op 0) to an UNCACHED or CLEAN block is answered with a shared grant (msg_type 0) to the requester. The entry becomes CLEAN with the requester's bit added.
- R4: An exclusive grant (msg_type 1) is sent at once in three cases: a write (req_op 1) to an UNCACHED block, a write to a CLEAN block with no holder other than the requester, and any read or write from the current DIRTY owner. In the first two cases the entry becomes DIRTY with only the requester's bit. In the third it is unchanged. A DIRTY entry always has exactly one bit set.
- R5: A write to a CLEAN block that has other holders sends one invalidate (msg_type 2) to each of them, lowest cluster number first, and never one to the requester. The exclusive grant follows only after an invalidate acknowledgement (ack_kind 0) from every one of them. The entry then becomes DIRTY with only the requester's bit.
- R6: While a transaction is pending, a request is answered with a retry (msg_type 5) if it targets the pending block or would itself need invalidations or a forward. Other requests are served normally.
- R7: An acknowledgement from a cluster that is not owed one, or with the wrong ack_kind, has no effect. No bit is ever added to the owed set during a transaction.
- R8: A read to a block DIRTY at another cluster sends a read forward (msg_type 3) to the owner. After the owner's completion (ack_kind 1), a shared grant goes to the requester and the entry becomes CLEAN with both clusters' bits.
- R9: A write to a block DIRTY at another cluster sends a write forward (msg_type 4) to the owner. After the owner's completion, an exclusive grant goes to the requester, which becomes the only set bit.
- R10: A writeback (req_op 2) from the DIRTY owner makes the entry UNCACHED with an empty bitmap. A writeback from any other cluster changes nothing. Neither sends a message.
- R11: A request whose region bits (top IDW address bits) differ from HOME_ID, or whose req_op is 3, is answered with a retry (msg_type 5) and changes no entry.
- R12: While msg_valid is 1 and msg_ready is 0, the message fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken this cycle when valid |
| req_src | input | IDW | Requesting cluster |
| req_op | input | 2 | 0 read, 1 write, 2 writeback, 3 reserved |
| req_addr | input | AW | Byte address: region, index, offset |
| ack_valid | input | 1 | Acknowledgement strobe |
| ack_src | input | IDW | Acknowledging cluster |
| ack_kind | input | 1 | 0 invalidate done, 1 forward done |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message taken this cycle when valid |
| msg_dst | output | IDW | Destination cluster |
| msg_type | output | 3 | 0 shared, 1 exclusive, 2 invalidate, 3 read forward, 4 write forward, 5 retry |
| msg_addr | output | AW | Block address, offset zero |

## Verification
A corrupted bitmap or state field stays hidden until the next request to that block. At that point it shows up in the reply to the requester: a forward where a grant was due, an invalidate to the wrong cluster, or a missing one. That reply appears one cycle after the request is accepted, or as soon as the message channel drains. A wrong owed set or a miscounted acknowledgement shows up as a grant that arrives before the last acknowledgement, or never arrives. A pending flag left set shows up as a retry on the next request to that block.

// File: rtl/dir_pkg.sv
package dir_pkg;
   typedef enum logic [1:0] {BS_UNC = 2'd0, BS_CLN = 2'd1, BS_DRT = 2'd2} blk_state_e;
   typedef enum logic [1:0] {RQ_READ = 2'd0, RQ_WRITE = 2'd1, RQ_WBACK = 2'd2, RQ_RSVD = 2'd3} req_op_e;
   typedef enum logic [2:0] {
      MS_SHARED = 3'd0, MS_EXCL = 3'd1, MS_INVAL = 3'd2,
      MS_FWD_RD = 3'd3, MS_FWD_WR = 3'd4, MS_NAK = 3'd5
   } msg_type_e;
   typedef enum logic {AK_INV = 1'b0, AK_FWD = 1'b1} ack_kind_e;
   typedef enum logic [1:0] {PH_IDLE, PH_INV, PH_WAIT, PH_GRANT} phase_e;
endpackage

// File: rtl/dir_store.sv
module dir_store
   import dir_pkg::*;
#(
   parameter int NCLU  = 16,
   parameter int DEPTH = 16,
   parameter int IDXW  = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDXW-1:0]  rd_idx,
   output blk_state_e       rd_state,
   output logic [NCLU-1:0]  rd_map,
   input  logic             wr_en,
   input  logic [IDXW-1:0]  wr_idx,
   input  blk_state_e       wr_state,
   input  logic [NCLU-1:0]  wr_map
);
   blk_state_e      st_q  [DEPTH];
   logic [NCLU-1:0] map_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            st_q[i]  <= BS_UNC;
            map_q[i] <= '0;
         end
      end else if (wr_en) begin
         st_q[wr_idx]  <= wr_state;
         map_q[wr_idx] <= wr_map;
      end
   end

   assign rd_state = st_q[rd_idx];
   assign rd_map   = map_q[rd_idx];
endmodule

// File: rtl/dir_lowbit.sv
module dir_lowbit #(
   parameter int W  = 16,
   parameter int IW = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end
   assign any = |vec;
endmodule

// File: rtl/dir_msg_slot.sv
module dir_msg_slot #(
   parameter int IDW       = 4,
   parameter int AW        = 12,
   parameter bit FULL_RATE = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [IDW-1:0] ld_dst,
   input  logic [2:0]     ld_type,
   input  logic [AW-1:0]  ld_addr,
   input  logic           out_ready,
   output logic           free,
   output logic           out_valid,
   output logic [IDW-1:0] out_dst,
   output logic [2:0]     out_type,
   output logic [AW-1:0]  out_addr
);
   generate
      if (FULL_RATE) begin : g_pass
         assign free = !out_valid || out_ready;
      end else begin : g_bubble
         assign free = !out_valid;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_dst   <= '0;
         out_type  <= '0;
         out_addr  <= '0;
      end else if (load) begin
         out_valid <= 1'b1;
         out_dst   <= ld_dst;
         out_type  <= ld_type;
         out_addr  <= ld_addr;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
   import dir_pkg::*;
#(
   parameter int NCLU      = 16,
   parameter int DEPTH     = 16,
   parameter int BLK_BYTES = 16,
   parameter int HOME_ID   = 5,
   parameter bit FULL_RATE = 1'b1,
   parameter int IDW       = $clog2(NCLU),
   parameter int IDXW      = $clog2(DEPTH),
   parameter int OFFW      = $clog2(BLK_BYTES),
   parameter int AW        = IDW + IDXW + OFFW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   output logic           req_ready,
   input  logic [IDW-1:0] req_src,
   input  logic [1:0]     req_op,
   input  logic [AW-1:0]  req_addr,
   input  logic           ack_valid,
   input  logic [IDW-1:0] ack_src,
   input  logic           ack_kind,
   output logic           msg_valid,
   input  logic           msg_ready,
   output logic [IDW-1:0] msg_dst,
   output logic [2:0]     msg_type,
   output logic [AW-1:0]  msg_addr
);
   localparam logic [IDW-1:0] HOME = IDW'(HOME_ID);

   generate
      if (NCLU < 2 || (1 << IDW) != NCLU) begin : g_bad_nclu
         $error("NCLU must be a power of two of at least 2");
      end
      if (DEPTH < 2 || (1 << IDXW) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (BLK_BYTES < 2 || (1 << OFFW) != BLK_BYTES) begin : g_bad_blk
         $error("BLK_BYTES must be a power of two of at least 2");
      end
      if (HOME_ID < 0 || HOME_ID >= NCLU) begin : g_bad_home
         $error("HOME_ID out of range");
      end
   endgenerate

   logic [IDW-1:0]  rq_region;
   logic [IDXW-1:0] rq_idx;
   logic            unused_offset_bits;
   assign rq_region          = req_addr[AW-1 -: IDW];
   assign rq_idx             = req_addr[OFFW +: IDXW];
   assign unused_offset_bits = ^req_addr[OFFW-1:0];

   phase_e          phase_q;
   logic [IDXW-1:0] pend_idx_q;
   logic [IDW-1:0]  pend_req_q;
   logic            pend_rd_q;
   ack_kind_e       pend_kind_q;
   logic [NCLU-1:0] send_q, owed_q, keep_q;
   logic [AW-1:0]   pend_addr;
   assign pend_addr = {HOME, pend_idx_q, {OFFW{1'b0}}};

   blk_state_e      ent_st, wr_st;
   logic [NCLU-1:0] ent_map, wr_map;
   logic [IDXW-1:0] wr_idx;
   logic            wr_en;

   dir_store #(.NCLU(NCLU), .DEPTH(DEPTH), .IDXW(IDXW)) u_store (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(rq_idx), .rd_state(ent_st), .rd_map(ent_map),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_state(wr_st), .wr_map(wr_map)
   );

   logic [IDW-1:0] owner_idx, inv_idx;
   logic           owner_any, inv_any;
   dir_lowbit #(.W(NCLU), .IW(IDW)) u_owner (.vec(ent_map), .idx(owner_idx), .any(owner_any));
   dir_lowbit #(.W(NCLU), .IW(IDW)) u_next_inv (.vec(send_q), .idx(inv_idx), .any(inv_any));

   logic           ld, slot_free;
   logic [IDW-1:0] ld_dst;
   logic [2:0]     ld_type;
   logic [AW-1:0]  ld_addr;

   dir_msg_slot #(.IDW(IDW), .AW(AW), .FULL_RATE(FULL_RATE)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .load(ld), .ld_dst(ld_dst), .ld_type(ld_type), .ld_addr(ld_addr),
      .out_ready(msg_ready), .free(slot_free),
      .out_valid(msg_valid), .out_dst(msg_dst), .out_type(msg_type), .out_addr(msg_addr)
   );

   req_op_e         op;
   logic [NCLU-1:0] src_bit, others, inv_bit, ack_clear;
   logic            busy, is_owner, bad, needs_wait, nak, accept;
   logic            start_inv, start_fwd;

   assign op         = req_op_e'(req_op);
   assign src_bit    = NCLU'(1) << req_src;
   assign others     = ent_map & ~src_bit;
   assign inv_bit    = NCLU'(1) << inv_idx;
   assign busy       = phase_q != PH_IDLE;
   assign is_owner   = (ent_st == BS_DRT) && owner_any && (owner_idx == req_src);
   assign bad        = (rq_region != HOME) || (op == RQ_RSVD);
   assign needs_wait = ((ent_st == BS_DRT) && !is_owner && (op != RQ_WBACK)) ||
                       ((op == RQ_WRITE) && (ent_st == BS_CLN) && (others != '0));
   assign nak        = bad || (busy && ((rq_idx == pend_idx_q) || needs_wait));
   assign req_ready  = slot_free && ((phase_q == PH_IDLE) || (phase_q == PH_WAIT));
   assign accept     = req_valid && req_ready;
   assign ack_clear  = (ack_valid && busy && (ack_kind_e'(ack_kind) == pend_kind_q)) ?
                       (NCLU'(1) << ack_src) : '0;

   always_comb begin
      ld        = 1'b0;
      ld_dst    = req_src;
      ld_type   = MS_NAK;
      ld_addr   = {rq_region, rq_idx, {OFFW{1'b0}}};
      wr_en     = 1'b0;
      wr_idx    = rq_idx;
      wr_st     = ent_st;
      wr_map    = ent_map;
      start_inv = 1'b0;
      start_fwd = 1'b0;
      case (phase_q)
         PH_INV: begin
            if (slot_free && inv_any) begin
               ld      = 1'b1;
               ld_dst  = inv_idx;
               ld_type = MS_INVAL;
               ld_addr = pend_addr;
            end
         end
         PH_GRANT: begin
            if (slot_free) begin
               ld      = 1'b1;
               ld_dst  = pend_req_q;
               ld_type = pend_rd_q ? MS_SHARED : MS_EXCL;
               ld_addr = pend_addr;
               wr_en   = 1'b1;
               wr_idx  = pend_idx_q;
               wr_st   = pend_rd_q ? BS_CLN : BS_DRT;
               wr_map  = (pend_rd_q ? keep_q : '0) | (NCLU'(1) << pend_req_q);
            end
         end
         default: begin
            if (accept) begin
               if (nak) begin
                  ld = 1'b1;
               end else begin
                  case (op)
                     RQ_READ, RQ_WRITE: begin
                        if (ent_st == BS_DRT) begin
                           ld = 1'b1;
                           if (is_owner) begin
                              ld_type = MS_EXCL;
                           end else begin
                              ld_dst    = owner_idx;
                              ld_type   = (op == RQ_READ) ? MS_FWD_RD : MS_FWD_WR;
                              start_fwd = 1'b1;
                           end
                        end else if (op == RQ_READ) begin
                           ld      = 1'b1;
                           ld_type = MS_SHARED;
                           wr_en   = 1'b1;
                           wr_st   = BS_CLN;
                           wr_map  = ent_map | src_bit;
                        end else if ((ent_st == BS_CLN) && (others != '0)) begin
                           start_inv = 1'b1;
                        end else begin
                           ld      = 1'b1;
                           ld_type = MS_EXCL;
                           wr_en   = 1'b1;
                           wr_st   = BS_DRT;
                           wr_map  = src_bit;
                        end
                     end
                     RQ_WBACK: begin
                        if (is_owner) begin
                           wr_en  = 1'b1;
                           wr_st  = BS_UNC;
                           wr_map = '0;
                        end
                     end
                     default: ;
                  endcase
               end
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         pend_idx_q  <= '0;
         pend_req_q  <= '0;
         pend_rd_q   <= 1'b0;
         pend_kind_q <= AK_INV;
         send_q      <= '0;
         owed_q      <= '0;
         keep_q      <= '0;
      end else if (start_inv || start_fwd) begin
         pend_idx_q  <= rq_idx;
         pend_req_q  <= req_src;
         pend_rd_q   <= start_fwd && (op == RQ_READ);
         pend_kind_q <= start_inv ? AK_INV : AK_FWD;
         send_q      <= start_inv ? others : '0;
         owed_q      <= start_inv ? others : (NCLU'(1) << owner_idx);
         keep_q      <= ent_map;
         phase_q     <= start_inv ? PH_INV : PH_WAIT;
      end else begin
         owed_q <= owed_q & ~ack_clear;
         case (phase_q)
            PH_INV: begin
               if (slot_free) begin
                  send_q <= send_q & ~inv_bit;
                  if (send_q == inv_bit) phase_q <= PH_WAIT;
               end
            end
            PH_WAIT:  if (owed_q == '0) phase_q <= PH_GRANT;
            PH_GRANT: if (slot_free) phase_q <= PH_IDLE;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/dir_home_ctrl_chk.sv
module dir_home_ctrl_chk #(
   parameter int NCLU    = 16,
   parameter int IDW     = 4,
   parameter int IDXW    = 4,
   parameter int OFFW    = 4,
   parameter int AW      = 12,
   parameter int HOME_ID = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic [IDW-1:0]  req_src,
   input logic [AW-1:0]   req_addr,
   input logic            msg_valid,
   input logic            msg_ready,
   input logic [IDW-1:0]  msg_dst,
   input logic [2:0]      msg_type,
   input logic [AW-1:0]   msg_addr,
   input logic            busy,
   input logic [IDXW-1:0] pend_idx,
   input logic [IDW-1:0]  pend_req,
   input logic [NCLU-1:0] owed,
   input logic [1:0]      ent_st,
   input logic [NCLU-1:0] ent_map
);
   logic            hs;
   logic [IDW-1:0]  c_region;
   logic [IDXW-1:0] c_idx;
   logic            unused_chk_bits;
   assign hs              = req_valid && req_ready;
   assign c_region        = req_addr[AW-1 -: IDW];
   assign c_idx           = req_addr[OFFW +: IDXW];
   assign unused_chk_bits = ^req_addr[OFFW-1:0];

   // R12
   msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_dst) && $stable(msg_type) && $stable(msg_addr)));

   // R11
   bad_region_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hs && (c_region != IDW'(HOME_ID))) |=> (msg_valid && (msg_type == 3'd5) && (msg_dst == $past(req_src))));

   // R6
   busy_block_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hs && busy && (c_idx == pend_idx)) |=> (msg_valid && (msg_type == 3'd5) && (msg_dst == $past(req_src))));

   // R5
   inval_not_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && msg_valid && (msg_type == 3'd2)) |-> (msg_dst != pend_req));

   // R7
   owed_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ((owed & ~$past(owed)) == '0));

   // R4
   dirty_one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_st == 2'd2) |-> ($countones(ent_map) == 1));

   // R10
   uncached_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_st == 2'd0) |-> (ent_map == '0));

   // R3
   state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ent_st != 2'd3);

   // R2
   addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> (msg_addr[OFFW-1:0] == '0));
endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(
   .NCLU(NCLU), .IDW(IDW), .IDXW(IDXW), .OFFW(OFFW), .AW(AW), .HOME_ID(HOME_ID)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src), .req_addr(req_addr),
   .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dst(msg_dst), .msg_type(msg_type),
   .msg_addr(msg_addr), .busy(busy), .pend_idx(pend_idx_q), .pend_req(pend_req_q),
   .owed(owed_q), .ent_st(ent_st), .ent_map(ent_map)
);

// File: tb/dir_home_ctrl_bench.sv
`timescale 1ns/1ps
module dir_home_ctrl_bench;
   localparam int HOME = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [3:0]  req_src = '0;
   logic [1:0]  req_op = '0;
   logic [11:0] req_addr = '0;
   logic        ack_valid = 1'b0;
   logic [3:0]  ack_src = '0;
   logic        ack_kind = 1'b0;
   logic        msg_valid;
   logic        msg_ready = 1'b1;
   logic [3:0]  msg_dst;
   logic [2:0]  msg_type;
   logic [11:0] msg_addr;

   always #4 clk = ~clk;

   dir_home_ctrl #(.NCLU(16), .DEPTH(16), .BLK_BYTES(16), .HOME_ID(HOME)) u_dir_home_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src), .req_op(req_op),
      .req_addr(req_addr), .ack_valid(ack_valid), .ack_src(ack_src), .ack_kind(ack_kind),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dst(msg_dst), .msg_type(msg_type),
      .msg_addr(msg_addr)
   );

   typedef struct {int dst; int typ; int addr; string tag;} exp_t;
   exp_t q[$];
   int errors = 0;
   int checks = 0;
   bit run = 1'b0;

   int          mst  [16];
   logic [15:0] mmap [16];
   bit          mp = 1'b0;
   int          mpidx, mpreq, mpkind;
   bit          mprd;
   logic [15:0] mowed, mkeep;

   task automatic check(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic push(int d, int t, int a, string g);
      exp_t e;
      e.dst = d; e.typ = t; e.addr = a; e.tag = g;
      q.push_back(e);
   endtask

   function automatic int lowest(logic [15:0] m);
      for (int i = 0; i < 16; i++) if (m[i]) return i;
      return 0;
   endfunction

   task automatic model_req(int src, int op, int addr);
      int region, idx, al, st, own;
      logic [15:0] map, sb, oth;
      bit needw;
      region = (addr >> 8) & 15;
      idx    = (addr >> 4) & 15;
      al     = addr & 'hFF0;
      if (region != HOME || op == 3) begin
         push(src, 5, al, "R11");
         return;
      end
      st  = mst[idx];
      map = mmap[idx];
      own = lowest(map);
      sb  = 16'(1) << src;
      oth = map & ~sb;
      needw = (st == 2 && own != src && op != 2) || (op == 1 && st == 1 && oth != 0);
      if (mp && (idx == mpidx || needw)) begin
         push(src, 5, al, "R6");
         return;
      end
      if (op == 2) begin
         if (st == 2 && own == src) begin mst[idx] = 0; mmap[idx] = 0; end
         return;
      end
      if (st == 2) begin
         if (own == src) begin
            push(src, 1, al, "R4");
         end else begin
            push(own, (op == 0) ? 3 : 4, al, (op == 0) ? "R8" : "R9");
            mp = 1; mpidx = idx; mpreq = src; mpkind = 1; mprd = (op == 0);
            mowed = 16'(1) << own; mkeep = map;
         end
      end else if (op == 0) begin
         push(src, 0, al, "R3");
         mst[idx] = 1; mmap[idx] = map | sb;
      end else if (st == 1 && oth != 0) begin
         for (int i = 0; i < 16; i++) if (oth[i]) push(i, 2, al, "R5");
         mp = 1; mpidx = idx; mpreq = src; mpkind = 0; mprd = 0;
         mowed = oth; mkeep = 0;
      end else begin
         push(src, 1, al, "R4");
         mst[idx] = 2; mmap[idx] = sb;
      end
   endtask

   task automatic model_ack(int src, int kind);
      int al;
      if (mp && kind == mpkind && mowed[src]) begin
         mowed[src] = 1'b0;
         if (mowed == 0) begin
            al = (HOME << 8) | (mpidx << 4);
            if (mprd) begin
               push(mpreq, 0, al, "R8");
               mst[mpidx] = 1; mmap[mpidx] = mkeep | (16'(1) << mpreq);
            end else begin
               push(mpreq, 1, al, (mpkind == 0) ? "R5" : "R9");
               mst[mpidx] = 2; mmap[mpidx] = 16'(1) << mpreq;
            end
            mp = 0;
         end
      end
   endtask

   always @(negedge clk) begin
      if (run) begin
         if (msg_valid && msg_ready) begin
            if (q.size() == 0) begin
               check(1'b0, "R7", "unexpected message type", int'(msg_type), -1);
            end else begin
               exp_t e;
               bit ok;
               e = q.pop_front();
               ok = (int'(msg_dst) == e.dst) && (int'(msg_type) == e.typ) && (int'(msg_addr) == e.addr);
               checks++;
               if (!ok) begin
                  errors++;
                  $display("FAIL %s message dst/type/addr: got %0d/%0d/%h expected %0d/%0d/%h",
                           e.tag, msg_dst, msg_type, msg_addr, e.dst, e.typ, e.addr);
               end
            end
         end
         if (req_valid && req_ready) model_req(int'(req_src), int'(req_op), int'(req_addr));
         if (ack_valid) model_ack(int'(ack_src), int'(ack_kind));
      end
   end

   int cyc = 0;
   initial begin
      forever begin
         @(posedge clk);
         #1;
         cyc++;
         msg_ready = (cyc % 3) != 0;
      end
   end

   function automatic logic [11:0] blk(int idx, int off);
      return 12'((HOME << 8) | (idx << 4) | off);
   endfunction

   task automatic send_req(int src, int op, logic [11:0] addr);
      @(posedge clk); #1;
      req_valid = 1'b1; req_src = 4'(src); req_op = 2'(op); req_addr = addr;
      do @(negedge clk); while (!req_ready);
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic send_ack(int src, int kind);
      @(posedge clk); #1;
      ack_valid = 1'b1; ack_src = 4'(src); ack_kind = 1'(kind);
      @(posedge clk); #1;
      ack_valid = 1'b0;
   endtask

   task automatic drain();
      do @(negedge clk); while (q.size() != 0);
      repeat (2) @(negedge clk);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) begin mst[i] = 0; mmap[i] = '0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state at the ports
      check(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
      check(msg_valid == 1'b0, "R1", "msg_valid after reset", int'(msg_valid), 0);
      run = 1'b1;

      // R3 two readers make block 1 CLEAN
      send_req(3, 0, blk(1, 0));
      send_req(7, 0, blk(1, 0));
      drain();
      // R5 write to shared block: invalidates to 3 then 7
      send_req(9, 1, blk(1, 0));
      drain();
      send_ack(7, 0);
      // R7 acks from a non-sharer and with the wrong kind are ignored
      send_ack(12, 0);
      send_ack(3, 1);
      // R6 busy block refused, immediate request to another block served,
      // request that would itself wait is refused
      send_req(2, 0, blk(1, 0));
      send_req(4, 0, blk(2, 0));
      send_req(6, 1, blk(2, 0));
      drain();
      repeat (10) @(negedge clk);
      check(q.size() == 0, "R5", "grant queue before final ack", q.size(), 0);
      send_ack(3, 0);
      drain();

      // R8 read to dirty block forwarded, then shared grant
      send_req(4, 0, blk(1, 0));
      drain();
      send_ack(9, 1);
      drain();
      // R8 entry now holds 9 and 4: write by 4 invalidates 9 only
      send_req(4, 1, blk(1, 0));
      drain();
      send_ack(9, 0);
      drain();
      // R9 write to dirty block forwarded, ownership moves
      send_req(11, 1, blk(1, 0));
      drain();
      send_ack(4, 1);
      drain();
      // R10 writeback from non-owner ignored: a read still forwards to 11
      send_req(6, 2, blk(1, 0));
      send_req(2, 0, blk(1, 0));
      drain();
      send_ack(11, 1);
      drain();

      // R4 write to uncached block, R10 owner writeback, R4 owner re-read
      send_req(8, 1, blk(3, 0));
      send_req(8, 2, blk(3, 0));
      send_req(10, 1, blk(3, 0));
      send_req(10, 0, blk(3, 0));
      drain();
      // R4 sole sharer upgrades without invalidates
      send_req(6, 0, blk(4, 0));
      send_req(6, 1, blk(4, 0));
      drain();
      // R2 offset bits ignored, reply address aligned
      send_req(1, 0, blk(2, 11));
      // R11 foreign region and reserved opcode refused
      send_req(1, 0, 12'h324);
      send_req(1, 3, blk(5, 0));
      // R1 untouched last block answered from memory
      send_req(0, 0, blk(15, 0));
      drain();
      check(q.size() == 0, "R12", "undelivered messages", q.size(), 0);
      summary();
      $finish;
   end
endmodule